// File: doc/BRIEF.md
# Prioritized External Interrupt Request Latch

This block sits between the interrupt levels coming into a processor and the core's trap logic. It watches a vector of pending external interrupt levels, numbered 1 to 15, and keeps a registered trap index for the core. While the held index is empty or already describes an external interrupt, every clock edge re-arbitrates. The highest pending level wins. It is encoded as an external-interrupt trap type: a fixed tag in the upper bits, with the level number in the low bits.

A hard-interrupt request line goes to the core. It rises only when arbitration produces an index different from the one held. It falls when no level is pending any more or when the core clears the index. A synchronous exception code that the core has loaded is never overwritten by external levels. The core can also clear the index after it has taken the trap.

Top module: `ext_irq_latch`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `trap_idx` to 0 and `hard_req` to 0.
- R2: When arbitration applies, the new `trap_idx` is `{EXT_TAG, L}`, where L is the highest set bit of `irq_lvl` (bits 1 to 15). With the defaults, level L gives the trap type 0x10 + L.
- R3: Arbitration applies only when at least one level is pending and the held index is 0 or external. An index is external when its bits above the low 4 equal `EXT_TAG` (1 by default).
- R4: Arbitration follows the current pending set, so it moves the index to a lower level when the higher levels go away.
- R5: `hard_req` goes to 1 in the cycle after arbitration selects an index that differs from the held one.
- R6: When arbitration selects the index already held, `hard_req` keeps its value. In particular, a low request stays low.
- R7: With no level pending and an external index held, the next edge sets `trap_idx` to 0 and `hard_req` to 0.
- R8: A held non-zero, non-external index is left unchanged by any pending levels, and `hard_req` keeps its value.
- R9: `ld_en` writes `ld_code` into `trap_idx` and leaves `hard_req` unchanged. It takes priority over `clr_en` and over arbitration in the same cycle.
- R10: `clr_en` without `ld_en` sets `trap_idx` to 0 and `hard_req` to 0. Arbitration resumes from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_lvl | input | 15 ([15:1]) | Pending external interrupt levels, bit n = level n |
| ld_en | input | 1 | Core loads a synchronous exception code |
| ld_code | input | 8 | Code written by `ld_en` |
| clr_en | input | 1 | Core clears the index after taking the trap |
| trap_idx | output | 8 | Registered trap index |
| hard_req | output | 1 | Hard-interrupt request to the core |

## Verification
The bench builds the block with its default parameters: an 8-bit index, 4-bit level numbers and external tag 1. With these, every level from 1 to 15 and every boundary between external codes (0x11 to 0x1F) and other codes can be reached directly. Directed sequences cover level changes upwards and downwards and a reload of the same index with the request low. They also cover loads and clears that collide with arbitration. A long stretch of random levels, loads and clears is then compared against a behavioural model on every clock.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  // True when the bits above the level field carry the external tag.
  function automatic bit idx_is_ext(input int unsigned idx,
                                    input int unsigned lvl_w,
                                    input int unsigned tag);
    return (idx >> lvl_w) == tag;
  endfunction

  // External trap type for one level: tag in the upper bits, level below.
  function automatic int unsigned ext_code(input int unsigned lvl,
                                           input int unsigned lvl_w,
                                           input int unsigned tag);
    return (tag << lvl_w) | lvl;
  endfunction

endpackage

// File: rtl/ext_irq_prio.sv
module ext_irq_prio #(
  parameter int LVL_W = 4
) (
  input  logic [(1<<LVL_W)-1:1] lvl_vec,
  output logic                  any_pend,
  output logic [LVL_W-1:0]      top_lvl
);
  localparam int NLVL = 1 << LVL_W;

  logic [NLVL-1:1] higher;  // some level strictly above n is pending
  logic [NLVL-1:1] win;     // one-hot winner

  genvar n;
  generate
    for (n = NLVL - 1; n >= 1; n--) begin : g_chain
      if (n == NLVL - 1) begin : g_top
        assign higher[n] = 1'b0;
      end else begin : g_mid
        assign higher[n] = higher[n+1] | lvl_vec[n+1];
      end
      assign win[n] = lvl_vec[n] & ~higher[n];
    end
  endgenerate

  assign any_pend = |lvl_vec;

  always_comb begin
    top_lvl = '0;
    for (int k = 1; k < NLVL; k++) begin
      if (win[k]) top_lvl = top_lvl | LVL_W'(k);
    end
  end
endmodule

// File: rtl/ext_irq_ctl.sv
module ext_irq_ctl #(
  parameter int IDX_W   = 8,
  parameter int LVL_W   = 4,
  parameter int EXT_TAG = 1
) (
  input  logic             any_pend,
  input  logic [LVL_W-1:0] top_lvl,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic             cur_req,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_code,
  input  logic             clr_en,
  output logic [IDX_W-1:0] sel_idx,
  output logic             arb_ok,
  output logic             arb_new,
  output logic             arb_drop,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             nxt_req
);
  logic cur_ext;
  logic core_busy;

  assign cur_ext   = ext_irq_pkg::idx_is_ext(32'(cur_idx), LVL_W, EXT_TAG);
  assign sel_idx   = IDX_W'(ext_irq_pkg::ext_code(32'(top_lvl), LVL_W, EXT_TAG));
  assign core_busy = ld_en | clr_en;
  assign arb_ok    = !core_busy && any_pend && ((cur_idx == '0) || cur_ext);
  assign arb_new   = arb_ok && (sel_idx != cur_idx);
  assign arb_drop  = !core_busy && !any_pend && cur_ext;

  always_comb begin
    nxt_idx = cur_idx;
    nxt_req = cur_req;
    if (ld_en) begin
      nxt_idx = ld_code;
    end else if (clr_en) begin
      nxt_idx = '0;
      nxt_req = 1'b0;
    end else if (arb_ok) begin
      nxt_idx = sel_idx;
      if (arb_new) nxt_req = 1'b1;
    end else if (arb_drop) begin
      nxt_idx = '0;
      nxt_req = 1'b0;
    end
  end
endmodule

// File: rtl/ext_irq_reg.sv
module ext_irq_reg #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] nxt_idx,
  input  logic             nxt_req,
  output logic [IDX_W-1:0] idx_q,
  output logic             req_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      req_q <= 1'b0;
    end else begin
      idx_q <= nxt_idx;
      req_q <= nxt_req;
    end
  end
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch #(
  parameter int IDX_W   = 8,
  parameter int LVL_W   = 4,
  parameter int EXT_TAG = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [(1<<LVL_W)-1:1] irq_lvl,
  input  logic                  ld_en,
  input  logic [IDX_W-1:0]      ld_code,
  input  logic                  clr_en,
  output logic [IDX_W-1:0]      trap_idx,
  output logic                  hard_req
);
  // Named internal events, visible to the bound checker.
  logic             sel_valid;
  logic [LVL_W-1:0] sel_lvl;
  logic [IDX_W-1:0] sel_idx;
  logic             arb_ok;
  logic             arb_new;
  logic             arb_drop;
  logic [IDX_W-1:0] nxt_idx;
  logic             nxt_req;

  ext_irq_prio #(.LVL_W(LVL_W)) prio_i (
    .lvl_vec (irq_lvl),
    .any_pend(sel_valid),
    .top_lvl (sel_lvl)
  );

  ext_irq_ctl #(.IDX_W(IDX_W), .LVL_W(LVL_W), .EXT_TAG(EXT_TAG)) ctl_i (
    .any_pend(sel_valid),
    .top_lvl (sel_lvl),
    .cur_idx (trap_idx),
    .cur_req (hard_req),
    .ld_en   (ld_en),
    .ld_code (ld_code),
    .clr_en  (clr_en),
    .sel_idx (sel_idx),
    .arb_ok  (arb_ok),
    .arb_new (arb_new),
    .arb_drop(arb_drop),
    .nxt_idx (nxt_idx),
    .nxt_req (nxt_req)
  );

  ext_irq_reg #(.IDX_W(IDX_W)) reg_i (
    .clk    (clk),
    .rst    (rst),
    .nxt_idx(nxt_idx),
    .nxt_req(nxt_req),
    .idx_q  (trap_idx),
    .req_q  (hard_req)
  );
endmodule

// File: rtl/ext_irq_latch_chk.sv
module ext_irq_latch_chk #(
  parameter int IDX_W   = 8,
  parameter int LVL_W   = 4,
  parameter int EXT_TAG = 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic [(1<<LVL_W)-1:1] irq_lvl,
  input logic                  ld_en,
  input logic [IDX_W-1:0]      ld_code,
  input logic                  clr_en,
  input logic [IDX_W-1:0]      trap_idx,
  input logic                  hard_req,
  input logic                  sel_valid,
  input logic [IDX_W-1:0]      sel_idx
);
  logic held_ext;
  logic held_sync;
  assign held_ext  = ext_irq_pkg::idx_is_ext(32'(trap_idx), LVL_W, EXT_TAG);
  assign held_sync = (trap_idx != '0) && !held_ext;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (trap_idx == '0 && !hard_req));

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (trap_idx == $past(ld_code) && hard_req == $past(hard_req)));

  // R10
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !ld_en) |=> (trap_idx == '0 && !hard_req));

  // R8
  sync_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && !clr_en && held_sync) |=> ($stable(trap_idx) && $stable(hard_req)));

  // R7
  drop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && !clr_en && irq_lvl == '0 && held_ext) |=> (trap_idx == '0 && !hard_req));

  // R6
  same_level_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && !clr_en && !hard_req && sel_valid && sel_idx == trap_idx) |=> !hard_req);

  // R5
  rise_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hard_req) |-> (trap_idx != $past(trap_idx)));

  // R2
  sel_external_chk: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> ext_irq_pkg::idx_is_ext(32'(sel_idx), LVL_W, EXT_TAG));
endmodule

bind ext_irq_latch ext_irq_latch_chk #(
  .IDX_W(IDX_W), .LVL_W(LVL_W), .EXT_TAG(EXT_TAG)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .irq_lvl  (irq_lvl),
  .ld_en    (ld_en),
  .ld_code  (ld_code),
  .clr_en   (clr_en),
  .trap_idx (trap_idx),
  .hard_req (hard_req),
  .sel_valid(sel_valid),
  .sel_idx  (sel_idx)
);

// File: tb/ext_irq_latch_tb_top.sv
`timescale 1ns/1ps
module ext_irq_latch_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:1] irq_lvl = '0;
  logic        ld_en = 1'b0;
  logic [7:0]  ld_code = '0;
  logic        clr_en = 1'b0;
  logic [7:0]  trap_idx;
  logic        hard_req;

  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  string cur_tag = "R1";

  // behavioural reference state
  int m_idx = 0;
  int m_req = 0;

  always #5 clk = ~clk;

  ext_irq_latch dut_i (
    .clk(clk), .rst(rst), .irq_lvl(irq_lvl), .ld_en(ld_en),
    .ld_code(ld_code), .clr_en(clr_en), .trap_idx(trap_idx), .hard_req(hard_req)
  );

  always @(posedge clk) begin
    int hi;
    int cand;
    bit ext;
    if (rst) begin
      m_idx = 0; m_req = 0;
    end else if (ld_en) begin
      m_idx = int'(ld_code);
    end else if (clr_en) begin
      m_idx = 0; m_req = 0;
    end else begin
      hi = 0;
      for (int k = 15; k > 0; k--) begin
        if (irq_lvl[k] && hi == 0) hi = k;
      end
      ext = (m_idx / 16) == 1;
      if (hi != 0 && (m_idx == 0 || ext)) begin
        cand = 16 + hi;
        if (cand != m_idx) m_req = 1;
        m_idx = cand;
      end else if (hi == 0 && ext) begin
        m_idx = 0; m_req = 0;
      end
    end
  end

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (!finished) begin
      total++;
      if (int'(trap_idx) != m_idx || int'(hard_req) != m_req) begin
        bad++;
        $display("FAIL %s model: idx=%0h req=%0d expected idx=%0h req=%0d",
                 cur_tag, trap_idx, hard_req, m_idx, m_req);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input int e_idx, input int e_req, input string tag);
    #3;
    total++;
    if (int'(trap_idx) != e_idx || int'(hard_req) != e_req) begin
      bad++;
      $display("FAIL %s: idx=%0h req=%0d expected idx=%0h req=%0d",
               tag, trap_idx, hard_req, e_idx, e_req);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cur_tag = "R1";
    step(); step(); step();
    expect_out(0, 0, "R1");
    rst = 1'b0;
    // R2 and R5: a single level, then a higher one, then all of them
    cur_tag = "R2"; irq_lvl = 15'b0; irq_lvl[5] = 1'b1;
    step(); expect_out(8'h15, 1, "R2");
    irq_lvl[12] = 1'b1;
    step(); expect_out(8'h1c, 1, "R5");
    irq_lvl = '1;
    step(); expect_out(8'h1f, 1, "R2");
    // R4: falling back to a lower level
    cur_tag = "R4"; irq_lvl = '0; irq_lvl[1] = 1'b1;
    step(); expect_out(8'h11, 1, "R4");
    // R7: nothing pending clears the external index
    cur_tag = "R7"; irq_lvl = '0;
    step(); expect_out(0, 0, "R7");
    // R9 then R8: a loaded exception survives pending levels
    cur_tag = "R9"; irq_lvl[3] = 1'b1; ld_en = 1'b1; ld_code = 8'h2a;
    step(); expect_out(8'h2a, 0, "R9");
    cur_tag = "R8"; ld_en = 1'b0; irq_lvl = '1;
    for (int c = 0; c < 4; c++) begin
      step(); expect_out(8'h2a, 0, "R8");
    end
    // R10: clear, then arbitration resumes
    cur_tag = "R10"; irq_lvl = '0; irq_lvl[3] = 1'b1; clr_en = 1'b1;
    step(); expect_out(0, 0, "R10");
    clr_en = 1'b0;
    step(); expect_out(8'h13, 1, "R5");
    clr_en = 1'b1;
    step(); expect_out(0, 0, "R10");
    clr_en = 1'b0;
    step(); expect_out(8'h13, 1, "R3");
    // R9: load beats clear and keeps the request level
    cur_tag = "R9"; ld_en = 1'b1; clr_en = 1'b1; ld_code = 8'h07;
    step(); expect_out(8'h07, 1, "R9");
    ld_en = 1'b0; clr_en = 1'b0;
    step(); expect_out(8'h07, 1, "R8");
    // R6: same index reselected while request low stays quiet
    cur_tag = "R6"; rst = 1'b1; irq_lvl = '0;
    step(); expect_out(0, 0, "R1");
    rst = 1'b0; ld_en = 1'b1; ld_code = 8'h15;
    step(); expect_out(8'h15, 0, "R9");
    ld_en = 1'b0; irq_lvl[5] = 1'b1;
    step(); expect_out(8'h15, 0, "R6");
    step(); expect_out(8'h15, 0, "R6");
    irq_lvl[9] = 1'b1;
    step(); expect_out(8'h19, 1, "R5");
    // R3: loaded code just outside the external range blocks arbitration
    cur_tag = "R3"; ld_en = 1'b1; ld_code = 8'h20;
    step(); ld_en = 1'b0;
    step(); expect_out(8'h20, 1, "R3");
    // random stretch compared against the model each clock
    cur_tag = "R2";
    for (int c = 0; c < 3000; c++) begin
      int r;
      r = int'($urandom_range(0, 99));
      irq_lvl = (r < 20) ? 15'b0 : 15'($urandom);
      if (r < 40) irq_lvl = irq_lvl & 15'($urandom);
      ld_en   = (r % 17) == 3;
      clr_en  = (r % 11) == 5;
      ld_code = ((r % 3) == 0) ? 8'(16 + (r % 16)) : 8'($urandom);
      rst     = (r == 98);
      step();
    end
    rst = 1'b1; ld_en = 1'b0; clr_en = 1'b0;
    step(); expect_out(0, 0, "R1");
    rst = 1'b0;
    step();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule